// File: doc/BRIEF.md
# Direct-Mapped Read Cache with Victim Store

This block is a word-granular cache placed between a processor request port and a slower next-level memory. The main array is direct mapped: the block number taken from the byte address picks exactly one line, and a hit needs a single tag compare. Beside it sits a small fully associative victim store. It keeps lines that fills pushed out of the main array. When the main array misses but the victim store holds the block, the two lines trade places and the word is returned without a memory transaction. This removes much of the cost of two blocks that keep evicting each other from the same index.

The processor issues one request at a time while `cpu_ready` is high. A read returns its word through `cpu_rvalid`/`cpu_rdata`. Writes are write-through with no allocation on a miss. Each write updates whichever copy is resident and is always sent to memory. The memory port holds `mem_req` with a block number until `mem_ack`. On a read fetch, `mem_rdata` is taken in the cycle `mem_ack` is high. Every line holds one 32-bit word. The default index width is reduced for simulation; a 14-bit index gives the full 16K-line array.

Top module: `victim_dm_cache`

## Requirements
- R1: The byte address splits into a tag (top bits), a line index of `IDX_W` bits and a 2-bit word offset (bits 1:0). The offset never changes the word returned, and the block number sent to memory is address bits `ADDR_W-1:2`.
- R2: A read whose block is resident in the main array raises `cpu_rvalid` with the word on the clock edge that accepts the request, and makes no memory request.
- R3: A read that misses both structures drops `cpu_ready`. It then holds `mem_req` high with `mem_we` low and a stable `mem_addr` equal to the block number until `mem_ack`. It fills the indexed line and returns `mem_rdata` with `cpu_rvalid` on the edge where `mem_ack` is sampled high.
- R4: A valid line pushed out of the main array by a fill moves into the victim store. A later read of that block hits there, swaps it with the indexed main line and answers one edge after acceptance, with no memory request.
- R5: A line entering the victim store takes the lowest-numbered empty slot. When no slot is empty, it overwrites the slot named by a circular pointer, which then advances modulo `VB_N`. An overwritten block must be fetched again.
- R6: A write is always forwarded. `mem_req` and `mem_we` stay high with the block number and write data until `mem_ack`, `cpu_ready` is low meanwhile, and no `cpu_rvalid` is produced.
- R7: A write updates a resident copy in either structure, so a later read returns the new word with no fetch. A write that misses allocates nothing, so a later read of that block fetches.
- R8: Reset empties both structures and leaves `cpu_ready` high, `cpu_rvalid` low and `mem_req` low.
- R9: At most one victim slot matches a block, and no block is resident in both the main array and the victim store at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | Request, accepted when `cpu_ready` is high |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 32 | Write word |
| cpu_ready | output | 1 | Block idle and able to accept a request |
| cpu_rvalid | output | 1 | Read word valid, one cycle |
| cpu_rdata | output | 32 | Read word |
| mem_req | output | 1 | Memory transaction pending |
| mem_we | output | 1 | Pending transaction is a write |
| mem_addr | output | ADDR_W-2 | Block number |
| mem_wdata | output | 32 | Word to write |
| mem_ack | input | 1 | Memory completes the transaction this cycle |
| mem_rdata | input | 32 | Fetched word, valid with `mem_ack` |

## Verification
Two functions can land on the same clock edge: a fill that pushes a valid line out of the main array, and a victim insertion that must overwrite an occupied slot once all slots are full. The bench reaches this by reading six blocks that share one index. The fifth displaced line then meets a full victim store. The result is judged at the ports by which blocks still answer without a memory fetch and which need one. This includes a second overwrite after a swap, which shows that the pointer advanced.

// File: rtl/victim_dm_cache.sv
module victim_dm_cache #(
  parameter int ADDR_W = 24,
  parameter int IDX_W  = 6,
  parameter int VB_N   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [31:0]       cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_rvalid,
  output logic [31:0]       cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-3:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata
);
  localparam int BLK_W = ADDR_W - 2;
  localparam int TAG_W = BLK_W - IDX_W;
  localparam int LINES = 1 << IDX_W;
  localparam int VP_W  = $clog2(VB_N);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_WRITE} st_t;
  st_t state;

  logic [TAG_W-1:0] p_tag [LINES];
  logic [31:0]      p_dat [LINES];
  logic [LINES-1:0] p_val;
  logic [BLK_W-1:0] v_blk [VB_N];
  logic [31:0]      v_dat [VB_N];
  logic [VB_N-1:0]  v_val;
  logic [VP_W-1:0]  v_ptr;

  logic [BLK_W-1:0] r_blk;
  logic [31:0]      r_wdata;

  logic [BLK_W-1:0] look_blk;
  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic             phit, vany, vfree;
  logic [VB_N-1:0]  vhit_vec;
  logic [VP_W-1:0]  vsel, vfree_idx, ins;
  logic             accept, do_hit, do_swap, do_miss, do_wr, fill;
  logic             unused_off;

  assign unused_off = ^cpu_addr[1:0];
  assign look_blk   = (state == S_IDLE) ? cpu_addr[ADDR_W-1:2] : r_blk;
  assign idx        = look_blk[IDX_W-1:0];
  assign tag        = look_blk[BLK_W-1:IDX_W];
  assign phit       = p_val[idx] && (p_tag[idx] == tag);

  for (genvar g = 0; g < VB_N; g++) begin : g_vcmp
    assign vhit_vec[g] = v_val[g] && (v_blk[g] == look_blk);
  end

  assign vany  = |vhit_vec;
  assign vfree = ~&v_val;

  always_comb begin
    vsel      = '0;
    vfree_idx = '0;
    for (int i = 0; i < VB_N; i++)
      if (vhit_vec[i]) vsel = VP_W'(i);
    for (int i = VB_N - 1; i >= 0; i--)
      if (!v_val[i]) vfree_idx = VP_W'(i);
  end

  assign ins     = vfree ? vfree_idx : v_ptr;
  assign accept  = cpu_req && (state == S_IDLE);
  assign do_hit  = accept && !cpu_we && phit;
  assign do_swap = accept && !cpu_we && !phit && vany;
  assign do_miss = accept && !cpu_we && !phit && !vany;
  assign do_wr   = accept && cpu_we;
  assign fill    = (state == S_FETCH) && mem_ack;

  assign cpu_ready = (state == S_IDLE);
  assign mem_req   = (state != S_IDLE);
  assign mem_we    = (state == S_WRITE);
  assign mem_addr  = r_blk;
  assign mem_wdata = r_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      p_val      <= '0;
      v_val      <= '0;
      v_ptr      <= '0;
      cpu_rvalid <= 1'b0;
      cpu_rdata  <= '0;
      r_blk      <= '0;
      r_wdata    <= '0;
    end else begin
      cpu_rvalid <= 1'b0;
      if (do_hit) begin
        cpu_rvalid <= 1'b1;
        cpu_rdata  <= p_dat[idx];
      end
      if (do_swap) begin
        cpu_rvalid  <= 1'b1;
        cpu_rdata   <= v_dat[vsel];
        p_val[idx]  <= 1'b1;
        v_val[vsel] <= p_val[idx];
      end
      if (do_miss || do_wr) begin
        r_blk   <= cpu_addr[ADDR_W-1:2];
        r_wdata <= cpu_wdata;
        state   <= do_wr ? S_WRITE : S_FETCH;
      end
      if (fill) begin
        cpu_rvalid <= 1'b1;
        cpu_rdata  <= mem_rdata;
        p_val[idx] <= 1'b1;
        state      <= S_IDLE;
        if (p_val[idx]) begin
          v_val[ins] <= 1'b1;
          if (!vfree) v_ptr <= (v_ptr == VP_W'(VB_N - 1)) ? '0 : v_ptr + 1'b1;
        end
      end
      if (state == S_WRITE && mem_ack) state <= S_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (do_swap) begin
      p_tag[idx]  <= v_blk[vsel][BLK_W-1:IDX_W];
      p_dat[idx]  <= v_dat[vsel];
      v_blk[vsel] <= {p_tag[idx], idx};
      v_dat[vsel] <= p_dat[idx];
    end
    if (do_wr) begin
      if (phit) p_dat[idx]  <= cpu_wdata;
      if (vany) v_dat[vsel] <= cpu_wdata;
    end
    if (fill) begin
      p_tag[idx] <= tag;
      p_dat[idx] <= mem_rdata;
      if (p_val[idx]) begin
        v_blk[ins] <= {p_tag[idx], idx};
        v_dat[ins] <= p_dat[idx];
      end
    end
  end
endmodule

// File: rtl/victim_dm_cache_chk.sv
module victim_dm_cache_chk #(
  parameter int VB_N  = 4,
  parameter int BLK_W = 22
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_req,
  input logic             cpu_we,
  input logic             cpu_ready,
  input logic             cpu_rvalid,
  input logic             mem_req,
  input logic             mem_we,
  input logic             mem_ack,
  input logic [BLK_W-1:0] mem_addr,
  input logic             phit,
  input logic [VB_N-1:0]  vhit_vec
);
  // R3
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

  // R3
  fill_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we && mem_ack |=> cpu_rvalid);

  // R2
  hit_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && cpu_ready && !cpu_we && phit |=> cpu_rvalid && !mem_req);

  // R4
  vhit_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && cpu_ready && !cpu_we && (|vhit_vec) |=> cpu_rvalid && !mem_req);

  // R6
  wr_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && cpu_ready && cpu_we |=> mem_req && mem_we && !cpu_rvalid);

  // R9
  vhit_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vhit_vec));

  // R9
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(phit && (|vhit_vec)));
endmodule

bind victim_dm_cache victim_dm_cache_chk #(.VB_N(VB_N), .BLK_W(ADDR_W - 2)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
  .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid), .mem_req(mem_req),
  .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .phit(phit), .vhit_vec(vhit_vec)
);

// File: tb/victim_dm_cache_bench.sv
module victim_dm_cache_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [23:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_ready, cpu_rvalid;
  logic [31:0] cpu_rdata;
  logic        mem_req, mem_we;
  logic [21:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  int checks = 0, errors = 0, fetches = 0, writes = 0, wait_cnt = 0;
  logic [21:0] last_wa;
  logic [31:0] last_wd;
  logic [31:0] wmem [logic [21:0]];
  logic [31:0] exp_q [$];
  string       req_q [$];
  bit          done = 0;

  always #4 clk = ~clk;

  victim_dm_cache u_victim_dm_cache (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
    .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] model(input logic [21:0] b);
    if (wmem.exists(b)) return wmem[b];
    return {10'h2B5, b};
  endfunction

  function automatic logic [23:0] mk(input int t, input int i, input int off);
    return {t[15:0], i[5:0], off[1:0]};
  endfunction

  task automatic check(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  // next-level memory: acknowledges on the third cycle of a request
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack  = 1'b0;
      wait_cnt = 0;
    end else if (mem_req) begin
      wait_cnt++;
      if (wait_cnt == 3) begin
        mem_ack = 1'b1;
        if (mem_we) begin
          wmem[mem_addr] = mem_wdata;
          writes++;
          last_wa = mem_addr;
          last_wd = mem_wdata;
        end else begin
          mem_rdata = model(mem_addr);
          fetches++;
        end
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && cpu_rvalid) begin
      if (exp_q.size() == 0) begin
        check(0, "R6 unexpected read return", cpu_rdata, 32'h0);
      end else begin
        logic [31:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        check(cpu_rdata == e, r, cpu_rdata, e);
      end
    end
  end

  task automatic do_read(input logic [23:0] a, input bit no_fetch, input string r);
    int f0;
    while (!cpu_ready) @(negedge clk);
    f0 = fetches;
    exp_q.push_back(model(a[23:2]));
    req_q.push_back(r);
    cpu_addr = a; cpu_we = 1'b0; cpu_req = 1'b1;
    @(negedge clk);
    cpu_req = 1'b0;
    if (no_fetch) begin
      check(cpu_rvalid === 1'b1, {r, " one-edge latency"}, {31'b0, cpu_rvalid}, 32'h1);
    end else begin
      // R3 port held with block number while fetching
      check(!cpu_ready && mem_req && !mem_we && mem_addr == a[23:2],
            {r, " fetch request"}, {10'b0, mem_addr}, {10'b0, a[23:2]});
    end
    while (!cpu_ready || exp_q.size() != 0) @(negedge clk);
    check(fetches - f0 == (no_fetch ? 0 : 1), {r, " fetch count"}, fetches - f0, no_fetch ? 0 : 1);
  endtask

  task automatic do_write(input logic [23:0] a, input logic [31:0] d);
    int w0;
    while (!cpu_ready) @(negedge clk);
    w0 = writes;
    cpu_addr = a; cpu_we = 1'b1; cpu_wdata = d; cpu_req = 1'b1;
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0;
    check(mem_req && mem_we && !cpu_ready, "R6 write forwarded", {30'b0, mem_req, mem_we}, 32'h3);
    while (!cpu_ready) @(negedge clk);
    @(negedge clk);
    check(writes - w0 == 1 && last_wa == a[23:2] && last_wd == d, "R6 write content", last_wd, d);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(cpu_ready && !cpu_rvalid && !mem_req, "R8 reset state",
          {29'b0, cpu_ready, cpu_rvalid, mem_req}, 32'h4);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    do_reset();
    do_read(mk(1, 5, 0), 0, "R3 cold miss A");
    do_read(mk(1, 5, 2), 1, "R1 R2 hit with offset");
    do_read(mk(2, 5, 0), 0, "R3 conflict miss B");
    do_read(mk(1, 5, 1), 1, "R4 victim hit A");
    do_read(mk(2, 5, 3), 1, "R4 victim hit B");
    do_write(mk(1, 5, 0), 32'hDEADBEEF);
    do_read(mk(1, 5, 0), 1, "R7 victim copy updated");
    do_write(mk(3, 7, 0), 32'h12345678);
    do_read(mk(3, 7, 0), 0, "R7 write miss not allocated");
    do_write(mk(3, 7, 0), 32'h0BADF00D);
    do_read(mk(3, 7, 0), 1, "R7 primary copy updated");
    do_reset();
    do_read(mk(1, 5, 0), 0, "R8 empty after reset");
    // R5 free slots first, then circular overwrite
    for (int t = 1; t <= 6; t++) do_read(mk(t, 9, 0), 0, "R5 fill chain");
    do_read(mk(2, 9, 0), 1, "R5 survivor hit");
    do_read(mk(1, 9, 0), 0, "R5 oldest overwritten");
    do_read(mk(3, 9, 0), 1, "R5 survivor after overwrite");
    do_read(mk(6, 9, 0), 0, "R5 pointer advanced");
    do_read(mk(5, 9, 0), 1, "R5 slot zero kept");
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule